// File: doc/BRIEF.md
# Dual-Half NAND Page ECC Generator

This block computes a Hamming-style check code over the bytes of a 512-byte NAND page while those bytes pass the data port, for writes and for reads alike. The page is split into two 256-byte halves. Each half has its own accumulator holding 16 line-parity bits and 6 column-parity bits. Error correction is left to the host: it compares the code stored in the spare area with the freshly computed one.

Software drives the engine by writing 8-bit mode values. One value clears the parity state. One arms accumulation over the bytes that follow. One turns the data port into a result port. The six code bytes then come back as three 16-bit words in a fixed interleaved arrangement. A data-mode value leaves result mode. After the clear command the host performs one dummy byte access before arming calculation, and that access must not disturb the code.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset every readout word is 0xFFFF, because all parity state is zero and code bits are presented inverted.
- R2: Writing mode 0xF4 clears both parity sets and the byte count and puts the engine in idle. Every readout word is 0xFFFF afterwards.
- R3: Byte strobes outside calculation mode have no effect on the code. This includes the dummy access after 0xF4.
- R4: For each address bit k = 0..7 within a half, line bit 2k is the XOR of all bits of the bytes whose offset has bit k = 0, and line bit 2k+1 covers the bytes with bit k = 1.
- R5: For j = 0..2, column bit 2j is the XOR over all bytes of the data bits whose bit index has bit j = 0, and column bit 2j+1 covers those with bit j = 1. A column byte is {~CP5..~CP0, 2'b11}.
- R6: Once 0xB4 is written, the first 256 counted bytes feed the first parity set and the next 256 feed the second.
- R7: Bytes after the 512th counted byte are ignored until the next 0xF4.
- R8: Code bits are stored inverted. Word 0 = {~LP15..8, ~LP7..0} of half 0. Word 1 = {~LP7..0 of half 1, column byte of half 0}. Word 2 = {column byte of half 1, ~LP15..8 of half 1}.
- R9: Writing 0xD4 selects word 0. Each result read in result mode advances to the next word in the order 0, 1, 2, 0.
- R10: Writing 0xD4 or 0x94 resets the word index to 0, and 0x94 leaves result mode. `res_o` always shows the word at the current index, and reads outside result mode do not advance it.
- R11: Mode values other than 0xF4, 0xB4, 0xD4 and 0x94 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_i | input | 8 | Mode value written |
| byte_vld_i | input | 1 | One data byte transferred on the data port |
| byte_i | input | 8 | The transferred data byte |
| res_rd_i | input | 1 | 16-bit read of the data port |
| res_o | output | 16 | Readout word at the current index |

## Verification
The bench builds the block with its package defaults: 256-byte halves, 8-bit offsets and a 10-bit byte counter. Those values make full pages, partial pages stopping inside either half, and overlong streams of up to 600 bytes reachable within a few thousand cycles. A bench model of the two parity sets checks random byte streams of random lengths, together with directed single-byte and mode-sequencing cases.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int HALF_BYTES = 256;
  localparam int IDX_W      = $clog2(HALF_BYTES);
  localparam int LP_W       = 2 * IDX_W;
  localparam int DATA_W     = 8;
  localparam int CP_W       = 2 * $clog2(DATA_W);
  localparam int PAGE_BYTES = 2 * HALF_BYTES;
  localparam int CNT_W      = IDX_W + 2;
  localparam int WORDS      = 3;
  localparam int WIDX_W     = 2;

  localparam logic [7:0] MODE_CLEAR  = 8'hF4;
  localparam logic [7:0] MODE_CALC   = 8'hB4;
  localparam logic [7:0] MODE_RESULT = 8'hD4;
  localparam logic [7:0] MODE_DATA   = 8'h94;

  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_RESULT} ecc_st_e;

  typedef struct packed {
    logic [LP_W-1:0] lp;
    logic [CP_W-1:0] cp;
  } parity_t;
endpackage

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
  import nand_ecc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] byte_i,
  output parity_t           par_o
);
  parity_t acc_q, upd;
  logic    bpar;

  always_comb begin
    bpar = ^byte_i;
    upd  = '0;
    for (int k = 0; k < IDX_W; k++) begin
      upd.lp[2*k]   = bpar & ~idx_i[k];
      upd.lp[2*k+1] = bpar &  idx_i[k];
    end
    for (int j = 0; j < CP_W/2; j++) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (b[j]) upd.cp[2*j+1] = upd.cp[2*j+1] ^ byte_i[b];
        else      upd.cp[2*j]   = upd.cp[2*j]   ^ byte_i[b];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_q ^ upd;
  end

  assign par_o = acc_q;
endmodule

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import nand_ecc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [7:0]        mode_i,
  input  logic              byte_vld_i,
  input  logic              res_rd_i,
  output logic              clr_o,
  output logic [1:0]        en_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WIDX_W-1:0] widx_o,
  output logic [CNT_W-1:0]  cnt_o,
  output ecc_st_e           st_o
);
  ecc_st_e            st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WIDX_W-1:0]  widx_q;
  logic               take;

  assign clr_o = mode_we_i && (mode_i == MODE_CLEAR);
  assign take  = (st_q == ST_CALC) && byte_vld_i && !mode_we_i
                 && (cnt_q < CNT_W'(PAGE_BYTES));
  assign idx_o = cnt_q[IDX_W-1:0];
  assign en_o  = {take & cnt_q[IDX_W], take & ~cnt_q[IDX_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      widx_q <= '0;
    end else if (mode_we_i) begin
      case (mode_i)
        MODE_CLEAR:  begin st_q <= ST_IDLE; cnt_q <= '0; end
        MODE_CALC:   st_q <= ST_CALC;
        MODE_RESULT: begin st_q <= ST_RESULT; widx_q <= '0; end
        MODE_DATA:   begin st_q <= ST_IDLE; widx_q <= '0; end
        default: ;
      endcase
    end else begin
      if (take) cnt_q <= cnt_q + 1'b1;
      if (st_q == ST_RESULT && res_rd_i)
        widx_q <= (widx_q == WIDX_W'(WORDS-1)) ? '0 : widx_q + 1'b1;
    end
  end

  assign widx_o = widx_q;
  assign cnt_o  = cnt_q;
  assign st_o   = st_q;
endmodule

// File: rtl/ecc_readout.sv
module ecc_readout
  import nand_ecc_pkg::*;
(
  input  parity_t           par0_i,
  input  parity_t           par1_i,
  input  logic [WIDX_W-1:0] widx_i,
  output logic [15:0]       word_o
);
  logic [LP_W-1:0] lp0_n, lp1_n;
  logic [7:0]      cb0, cb1;

  assign lp0_n = ~par0_i.lp;
  assign lp1_n = ~par1_i.lp;
  assign cb0   = {~par0_i.cp, 2'b11};
  assign cb1   = {~par1_i.cp, 2'b11};

  always_comb begin
    case (widx_i)
      2'd0:    word_o = lp0_n;
      2'd1:    word_o = {lp1_n[7:0], cb0};
      2'd2:    word_o = {cb1, lp1_n[15:8]};
      default: word_o = 16'hFFFF;
    endcase
  end
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode_we_i,
  input  logic [7:0]  mode_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        res_rd_i,
  output logic [15:0] res_o
);
  logic              clr;
  logic [1:0]        en;
  logic [IDX_W-1:0]  idx;
  logic [WIDX_W-1:0] widx;
  logic [CNT_W-1:0]  byte_cnt;
  ecc_st_e           st;
  parity_t           par [2];

  ecc_ctrl i_ctrl (
    .clk_i, .rst_ni, .mode_we_i, .mode_i, .byte_vld_i, .res_rd_i,
    .clr_o(clr), .en_o(en), .idx_o(idx), .widx_o(widx),
    .cnt_o(byte_cnt), .st_o(st)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    ecc_half_acc i_acc (
      .clk_i, .rst_ni, .clr_i(clr), .en_i(en[h]), .idx_i(idx),
      .byte_i, .par_o(par[h])
    );
  end

  ecc_readout i_rd (
    .par0_i(par[0]), .par1_i(par[1]), .widx_i(widx), .word_o(res_o)
  );
endmodule

// File: rtl/nand_ecc_chk.sv
module nand_ecc_chk
  import nand_ecc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_we_i,
  input logic [7:0]        mode_i,
  input logic              byte_vld_i,
  input logic              res_rd_i,
  input logic [15:0]       res_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [WIDX_W-1:0] widx_i,
  input ecc_st_e           st_i
);
  p_cnt_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(PAGE_BYTES));

  p_cnt_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_CALC && byte_vld_i && !mode_we_i && cnt_i < CNT_W'(PAGE_BYTES))
    |=> cnt_i == $past(cnt_i) + 1'b1);

  p_full_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_W'(PAGE_BYTES) && !mode_we_i) |=> $stable(cnt_i));

  p_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i != ST_CALC && !mode_we_i) |=> $stable(cnt_i));

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && mode_i == MODE_CLEAR) |=> (res_o == 16'hFFFF && cnt_i == '0));

  p_widx_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    widx_i < WIDX_W'(WORDS));

  p_no_adv_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i != ST_RESULT && !mode_we_i) |=> $stable(widx_i));

  p_enter_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && (mode_i == MODE_RESULT || mode_i == MODE_DATA)) |=> widx_i == '0);
endmodule

bind nand_ecc_gen nand_ecc_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .mode_i(mode_i),
  .byte_vld_i(byte_vld_i), .res_rd_i(res_rd_i), .res_o(res_o),
  .cnt_i(byte_cnt), .widx_i(widx), .st_i(st)
);

// File: tb/test_nand_ecc_gen.sv
module test_nand_ecc_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [7:0]  mode = '0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        res_rd = 1'b0;
  logic [15:0] res;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] pg [512];
  int         n_pg = 0;

  always #2.5 clk = ~clk;

  nand_ecc_gen i_nand_ecc_gen (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_i(mode),
    .byte_vld_i(byte_vld), .byte_i(byte_d), .res_rd_i(res_rd), .res_o(res)
  );

  // inverted {lp[15:0], colbyte[7:0]} of half h from the bench page copy
  function automatic logic [23:0] half_code(int h);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int i = 0; i < 256; i++) begin
      int a = h * 256 + i;
      if (a < n_pg) begin
        logic p = ^pg[a];
        for (int k = 0; k < 8; k++)
          if (i[k]) lp[2*k+1] ^= p; else lp[2*k] ^= p;
        for (int j = 0; j < 3; j++)
          for (int b = 0; b < 8; b++)
            if (b[j]) cp[2*j+1] ^= pg[a][b]; else cp[2*j] ^= pg[a][b];
      end
    end
    return {~lp, ~cp, 2'b11};
  endfunction

  function automatic logic [15:0] exp_word(int w);
    logic [23:0] c0 = half_code(0);
    logic [23:0] c1 = half_code(1);
    case (w)
      0:       return c0[23:8];
      1:       return {c1[15:8], c0[7:0]};
      default: return {c1[7:0], c1[23:16]};
    endcase
  endfunction

  task automatic check(input logic [15:0] exp, input string req);
    n_chk++;
    if (res !== exp) begin
      n_bad++;
      $display("FAIL %s: res_o=%h expected %h", req, res, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] m);
    @(negedge clk); mode_we = 1'b1; mode = m;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    byte_vld = 1'b1; byte_d = b;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  // check word at current index, then pulse a read
  task automatic rd_check(input logic [15:0] exp, input string req);
    check(exp, req);
    res_rd = 1'b1;
    @(negedge clk); res_rd = 1'b0;
  endtask

  task automatic run_page(input int len, input bit rnd, input logic [7:0] fixed);
    wr_mode(8'hF4);
    put_byte(8'h5A);          // dummy access, R3
    wr_mode(8'hB4);
    n_pg = 0;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b = rnd ? 8'($urandom) : fixed;
      if (n_pg < 512) begin pg[n_pg] = b; n_pg++; end  // R7 model
      put_byte(b);
    end
    wr_mode(8'hD4);
  endtask

  initial begin
    void'($urandom(32'h1D2E3F));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(16'hFFFF, "R1 reset word0");
    wr_mode(8'hD4);
    for (int w = 0; w < 3; w++) rd_check(16'hFFFF, "R1 reset words");

    // single byte 0x01 at offset 0: R4/R5/R8 directed
    run_page(1, 0, 8'h01);
    rd_check(16'hAAAA, "R4 word0 single byte");
    rd_check(16'hFFAB, "R5 word1 single byte");
    rd_check(16'hFFFF, "R8 word2 single byte");
    check(16'hAAAA, "R9 wrap to word0");

    // all-0xFF full page
    run_page(512, 0, 8'hFF);
    for (int w = 0; w < 3; w++) rd_check(16'hFFFF, "R8 all-FF page");

    // random full page, read twice for wrap
    run_page(512, 1, 8'h00);
    for (int w = 0; w < 6; w++) rd_check(exp_word(w % 3), "R9 full page read with wrap");

    // partial page ending in first half (R6)
    run_page(100, 1, 8'h00);
    for (int w = 0; w < 3; w++) rd_check(exp_word(w), "R6 partial first half");

    // overlong stream (R7)
    run_page(600, 1, 8'h00);
    for (int w = 0; w < 3; w++) rd_check(exp_word(w), "R7 overlong stream");

    // R10: read once, leave with 0x94, read in idle must not advance
    run_page(300, 1, 8'h00);
    rd_check(exp_word(0), "R10 word0");
    check(exp_word(1), "R10 word1 before data mode");
    wr_mode(8'h94);
    check(exp_word(0), "R10 index reset by data mode");
    rd_check(exp_word(0), "R10 read in idle");
    check(exp_word(0), "R10 no advance in idle");

    // R11: unknown mode during calc leaves calc active; during result keeps index
    wr_mode(8'hF4);
    put_byte(8'h33);
    wr_mode(8'hB4);
    n_pg = 0;
    for (int i = 0; i < 280; i++) begin
      logic [7:0] b = 8'($urandom);
      if (i == 140) wr_mode(8'h00);
      pg[n_pg] = b; n_pg++;
      put_byte(b);
    end
    wr_mode(8'hD4);
    rd_check(exp_word(0), "R11 word0 after unknown mode");
    wr_mode(8'h6C);
    rd_check(exp_word(1), "R11 word1 index kept");
    rd_check(exp_word(2), "R11 word2");

    // R3: bytes in result mode ignored
    for (int i = 0; i < 20; i++) put_byte(8'($urandom));
    for (int w = 0; w < 3; w++) rd_check(exp_word(w), "R3 bytes in result mode ignored");

    // R2: clear
    wr_mode(8'hF4);
    wr_mode(8'hD4);
    for (int w = 0; w < 3; w++) rd_check(16'hFFFF, "R2 clear");

    // random rounds
    for (int r = 0; r < 20; r++) begin
      run_page(int'($urandom_range(0, 600)), 1, 8'h00);
      for (int w = 0; w < 3; w++) rd_check(exp_word(w), "R4 R5 random page");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule